// File: doc/BRIEF.md
# Framed Serial Command Master

This block is the host side of a three-wire command link. It drives a serial clock and a serial data-out line and listens on a serial data-in line. A one-cycle start request, given while the block is idle, captures a 32-bit command word. The block then frames the transfer with a start condition, shifts the command out most significant bit first, and collects one reply bit for every command bit. It closes the transfer with a stop condition and returns the assembled status word with a one-cycle done pulse.

Every level the block places on the pins is held for a fixed number of system clock cycles, called the half-period and set by a parameter. A start or stop condition is marked by a data-out edge while the serial clock is high. The data-out line otherwise changes only while the clock is low. The two most significant bits of the command select a page. In the returned status word these two bits replace the two most significant reply bits, so the status always carries the page it answers.

Top module: `sm_cmd_master`

## Requirements
- R1: Out of reset and whenever no transfer is in progress, the serial clock and data-out are both high, busy is low, and the status output reads zero until the first done pulse.
- R2: After a start request is accepted, data-out is low with the clock high for one half-period, then the clock is low with data-out low for one half-period. A falling data-out edge with the clock high occurs only in the first busy cycle.
- R3: Each command bit, starting from bit 31, is placed on data-out for three half-periods: clock low, clock high, clock low. While the clock stays high within a transfer, data-out never falls.
- R4: Data-in is sampled on the last cycle of the second low half-period of each bit, and the samples are shifted in most significant first.
- R5: After the last bit, data-out goes low with the clock low for one half-period. The clock then rises with data-out low for one half-period, and data-out then rises with the clock high for one half-period.
- R6: A done pulse lasts exactly one cycle, in the first cycle after the stop condition ends. With it the status is {command[31:30], reply[29:0]}. The status keeps that value until the next done pulse.
- R7: Busy is high from the cycle after acceptance until the done pulse, and it falls exactly when done rises. A start request while busy is ignored: the command being sent and the timing of the transfer are unchanged. A start request in the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled when idle |
| cmd_i | input | 32 | Command word, captured on acceptance |
| sdi_i | input | 1 | Serial data-in from the far end |
| sck_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data-out |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 32 | Assembled status word, page bits restored |

## Verification
The assertions assume that the system clock keeps running during reset and that reset is held low from time zero. They also assume that data-in is a plain level, so their pin-ordering properties depend only on the block's own outputs. The bench changes data-in only at a falling system-clock edge just after it sees the serial clock rise. This keeps the reply bit stable through the whole following high and low half-periods, so the sampled value is never ambiguous. Start requests and command changes are likewise driven at falling edges, and some are deliberately placed during a transfer and in the done cycle.

// File: rtl/sm_cmd_pkg.sv
// Shared types for the framed serial command master.
// Assumes nothing beyond a standard SystemVerilog package.
package sm_cmd_pkg;

    // Step of a transfer; each non-idle step lasts one half-period.
    typedef enum logic [3:0] {
        PH_IDLE      = 4'd0,
        PH_OPEN_HI   = 4'd1,
        PH_OPEN_LO   = 4'd2,
        PH_SETUP     = 4'd3,
        PH_RISE      = 4'd4,
        PH_FALL      = 4'd5,
        PH_CLOSE_LO  = 4'd6,
        PH_CLOSE_HI  = 4'd7,
        PH_CLOSE_END = 4'd8
    } sm_phase_t;

endpackage

// File: rtl/sm_cmd_seq.sv
// Step sequencer: walks the framing and per-bit steps, holding each step
// for HALF_CYC cycles. Assumes HALF_CYC >= 1 and WORD_W >= 2.
module sm_cmd_seq
    import sm_cmd_pkg::*;
#(
    parameter int HALF_CYC = 4,
    parameter int WORD_W   = 32
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    output sm_phase_t phase_o,
    output logic      accept_o,
    output logic      shift_o,
    output logic      finish_o
);
    localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CYC - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

    sm_phase_t        phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q;
    logic [BIT_W-1:0] bit_q;
    logic             tick;

    assign tick     = (cnt_q == CNT_LAST);
    assign accept_o = (phase_q == PH_IDLE) && start_i;
    assign shift_o  = (phase_q == PH_FALL) && tick;
    assign finish_o = (phase_q == PH_CLOSE_END) && tick;
    assign phase_o  = phase_q;

    // Next step: leave idle on a request, otherwise advance at interval end.
    always_comb begin
        phase_d = phase_q;
        if (phase_q == PH_IDLE) begin
            if (start_i) phase_d = PH_OPEN_HI;
        end else if (tick) begin
            case (phase_q)
                PH_OPEN_HI:   phase_d = PH_OPEN_LO;
                PH_OPEN_LO:   phase_d = PH_SETUP;
                PH_SETUP:     phase_d = PH_RISE;
                PH_RISE:      phase_d = PH_FALL;
                PH_FALL:      phase_d = (bit_q == BIT_LAST) ? PH_CLOSE_LO : PH_SETUP;
                PH_CLOSE_LO:  phase_d = PH_CLOSE_HI;
                PH_CLOSE_HI:  phase_d = PH_CLOSE_END;
                default:      phase_d = PH_IDLE;
            endcase
        end
    end

    // Step register, interval counter and bit index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
        end else begin
            phase_q <= phase_d;
            if (phase_q == PH_IDLE || tick) cnt_q <= '0;
            else                            cnt_q <= cnt_q + 1'b1;
            if (accept_o)     bit_q <= '0;
            else if (shift_o) bit_q <= bit_q + 1'b1;
        end
    end
endmodule

// File: rtl/sm_cmd_shift.sv
// Command and reply shift registers with page fix-up of the status word.
// Assumes load, shift and finish are never raised in the same cycle.
module sm_cmd_shift #(
    parameter int WORD_W = 32,
    parameter int PAGE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] cmd_i,
    input  logic              shift_i,
    input  logic              sdi_i,
    input  logic              finish_i,
    output logic              tx_msb_o,
    output logic              done_o,
    output logic [WORD_W-1:0] status_o
);
    localparam int RX_KEEP = WORD_W - PAGE_W;

    logic [WORD_W-1:0] tx_q, rx_q, stat_q;
    logic [PAGE_W-1:0] pg_q;
    logic              done_q;

    assign tx_msb_o = tx_q[WORD_W-1];
    assign done_o   = done_q;
    assign status_o = stat_q;

    // Outgoing command: load on accept, move left after each bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       tx_q <= '0;
        else if (load_i)  tx_q <= cmd_i;
        else if (shift_i) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
    end

    // Incoming reply: clear on accept, shift in one sample per bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_q <= '0;
        else if (load_i)  rx_q <= '0;
        else if (shift_i) rx_q <= {rx_q[WORD_W-2:0], sdi_i};
    end

    // Page bits of the command, kept for the status fix-up.
    always_ff @(posedge clk) begin
        if (!rst_n)      pg_q <= '0;
        else if (load_i) pg_q <= cmd_i[WORD_W-1 -: PAGE_W];
    end

    // Status word and done pulse at the end of the stop condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish_i;
            if (finish_i) stat_q <= {pg_q, rx_q[RX_KEEP-1:0]};
        end
    end
endmodule

// File: rtl/sm_cmd_master.sv
// Framed serial command master top: sequencer, shifters and pin decode.
// Pins are decoded from registered step state. Assumes sdi_i is stable
// around the sample point.
module sm_cmd_master
    import sm_cmd_pkg::*;
#(
    parameter int HALF_CYC = 4,
    parameter int WORD_W   = 32,
    parameter int PAGE_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] cmd_i,
    input  logic              sdi_i,
    output logic              sck_o,
    output logic              sdo_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] status_o
);
    sm_phase_t phase;
    logic      accept, shift, finish, tx_msb;

    sm_cmd_seq #(.HALF_CYC(HALF_CYC), .WORD_W(WORD_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .phase_o  (phase),
        .accept_o (accept),
        .shift_o  (shift),
        .finish_o (finish)
    );

    sm_cmd_shift #(.WORD_W(WORD_W), .PAGE_W(PAGE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .cmd_i    (cmd_i),
        .shift_i  (shift),
        .sdi_i    (sdi_i),
        .finish_i (finish),
        .tx_msb_o (tx_msb),
        .done_o   (done_o),
        .status_o (status_o)
    );

    assign busy_o = (phase != PH_IDLE);

    // Pin levels for each step.
    always_comb begin
        case (phase)
            PH_OPEN_HI:  begin sck_o = 1'b1; sdo_o = 1'b0;   end
            PH_OPEN_LO:  begin sck_o = 1'b0; sdo_o = 1'b0;   end
            PH_SETUP:    begin sck_o = 1'b0; sdo_o = tx_msb; end
            PH_RISE:     begin sck_o = 1'b1; sdo_o = tx_msb; end
            PH_FALL:     begin sck_o = 1'b0; sdo_o = tx_msb; end
            PH_CLOSE_LO: begin sck_o = 1'b0; sdo_o = 1'b0;   end
            PH_CLOSE_HI: begin sck_o = 1'b1; sdo_o = 1'b0;   end
            default:     begin sck_o = 1'b1; sdo_o = 1'b1;   end
        endcase
    end
endmodule

// File: rtl/sm_cmd_chk.sv
// Protocol checker for sm_cmd_master, attached by bind below.
// Assumes reset is low from time zero.
module sm_cmd_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sck,
    input logic              sdo,
    input logic              busy,
    input logic              done,
    input logic [WORD_W-1:0] status
);
    // R1: idle pins are high.
    p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck && sdo));

    // R2: a falling data-out edge with the clock high only opens a transfer.
    p_open_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sdo) && sck) |-> $rose(busy));

    // R3: inside a transfer, data-out never falls while the clock stays high.
    p_sdo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && sck && $past(sck)) |-> (sdo || !$past(sdo)));

    // R6: done lasts one cycle.
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: status only changes with done.
    p_status_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(status));

    // R7: busy falls exactly when done rises.
    p_busy_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
endmodule

bind sm_cmd_master sm_cmd_chk #(.WORD_W(WORD_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sck    (sck_o),
    .sdo    (sdo_o),
    .busy   (busy_o),
    .done   (done_o),
    .status (status_o)
);

// File: tb/sim_sm_cmd_master.sv
// Bench: behavioural per-cycle model (queue of expected pin levels)
// compared against the design on every falling clock edge.
module sim_sm_cmd_master;
    localparam int HALF = 4;
    localparam int W    = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  cmd = '0;
    logic          sdi = 1'b0;
    logic          sck, sdo, busy, done;
    logic [W-1:0]  status;

    int n_run = 0;
    int n_fail = 0;
    bit chk_en = 1'b0;

    logic [W-1:0] rsp = '0;

    always #5 clk = ~clk;

    sm_cmd_master #(.HALF_CYC(HALF), .WORD_W(W), .PAGE_W(2)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_i(cmd), .sdi_i(sdi),
        .sck_o(sck), .sdo_o(sdo), .busy_o(busy), .done_o(done), .status_o(status)
    );

    task automatic chk(input int req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    typedef struct { logic sck; logic sdo; int req; } step_t;
    step_t q[$];
    logic  m_busy = 1'b0, m_sck = 1'b1, m_sdo = 1'b1, m_done = 1'b0, m_pend = 1'b0;
    logic [W-1:0] m_status = '0, m_next = '0;
    int m_req = 1;

    task automatic push(input logic c, input logic d, input int req);
        step_t s;
        s.sck = c; s.sdo = d; s.req = req;
        for (int i = 0; i < HALF; i++) q.push_back(s);
    endtask

    // R2 open, R3 bits MSB first (low, high, low), R5 close.
    task automatic build(input logic [W-1:0] c);
        push(1'b1, 1'b0, 2);
        push(1'b0, 1'b0, 2);
        for (int b = W - 1; b >= 0; b--) begin
            push(1'b0, c[b], 3);
            push(1'b1, c[b], 3);
            push(1'b0, c[b], 3);
        end
        push(1'b0, 1'b0, 5);
        push(1'b1, 1'b0, 5);
        push(1'b1, 1'b1, 5);
    endtask

    always @(posedge clk) begin
        step_t s;
        if (!rst_n) begin
            q.delete();
            m_busy = 0; m_sck = 1; m_sdo = 1; m_done = 0; m_pend = 0; m_status = '0; m_req = 1;
        end else begin
            m_done = 0;
            // R7: accepted only when idle (done cycle counts as idle).
            if (q.size() == 0 && !m_pend && start) begin
                build(cmd);
                m_next = {cmd[W-1:W-2], rsp[W-3:0]};  // R4/R6 page fix-up
            end
            if (q.size() > 0) begin
                s = q.pop_front();
                m_busy = 1; m_sck = s.sck; m_sdo = s.sdo; m_req = s.req;
                if (q.size() == 0) m_pend = 1;
            end else if (m_pend) begin
                m_pend = 0; m_done = 1; m_status = m_next;
                m_busy = 0; m_sck = 1; m_sdo = 1; m_req = 6;
            end else begin
                m_busy = 0; m_sck = 1; m_sdo = 1; m_req = 1;
            end
        end
    end

    // Per-cycle comparison.
    always @(negedge clk) begin
        if (rst_n && chk_en) begin
            chk(m_req, "sck", W'(sck), W'(m_sck));
            chk(m_req, "sdo", W'(sdo), W'(m_sdo));
            chk(7, "busy", W'(busy), W'(m_busy));        // R7
            chk(6, "done", W'(done), W'(m_done));        // R6
            chk(m_done ? 4 : 6, "status", status, m_status); // R4 value, R6 hold
        end
    end

    // Far-end model: present the next reply bit just after each clock rise.
    int  k = 0;
    logic prev_sck = 1'b1;
    always @(negedge clk) begin
        if (!busy) k = 0;
        else if (sck && !prev_sck && k < W) begin
            sdi = rsp[W-1-k];
            k++;
        end
        prev_sck = sck;
    end

    task automatic wait_done();
        @(negedge clk);
        while (!done) @(negedge clk);
    endtask

    task automatic xfer(input logic [W-1:0] c, input logic [W-1:0] r);
        @(negedge clk);
        rsp = r; cmd = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(1, "reset sck", W'(sck), W'(1));
        chk(1, "reset sdo", W'(sdo), W'(1));
        chk(1, "reset busy", W'(busy), W'(0));
        chk(1, "reset done", W'(done), W'(0));
        chk(1, "reset status", status, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_en = 1'b1;
        repeat (4) @(negedge clk);

        // R3/R4: mixed patterns, edge words
        xfer(32'hA5C3_0F1E, 32'h3C5A_9687);
        xfer(32'hFFFF_FFFF, 32'h0000_0000);
        xfer(32'h0000_0000, 32'hFFFF_FFFF);
        xfer(32'h8000_0001, 32'h4000_0002);
        xfer(32'h5555_AAAA, 32'hAAAA_5555);

        // R7: start while busy is ignored
        @(negedge clk);
        rsp = 32'h1234_5678; cmd = 32'h4321_8765; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (50) @(negedge clk);
        cmd = 32'hC0DE_0000; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (200) @(negedge clk);
        cmd = 32'h0BAD_F00D; start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done();
        repeat (2) @(negedge clk);

        // R7: request held through the done cycle starts the next transfer
        @(negedge clk);
        rsp = 32'h9F00_00F9; cmd = 32'h7E81_18E7; start = 1'b1;
        wait_done();
        cmd = 32'hB00B_1E55;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (4) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule